// File: doc/BRIEF.md
# Cascadable serial bitstream memory

This block is a read-only serial memory that hands a fixed configuration bitstream to a programmable logic device one bit per clock. Its contents are set at elaboration through a parameter. An internal bit address counter walks the stored array, one step for every rising clock edge on which the device is selected. The current bit is driven onto a single tri-state data line.

Several devices can be chained. They all share the clock and the data line. The cascade output of one device drives the select input of the next, so the stream continues in the next device as soon as the first one reaches its last bit. A combined reset/output-enable input clears the counter and releases the line. Its active level is fixed by a parameter, so the block can sit beside receivers of either reset polarity.

Top module: `serial_cfg_mem`

## Requirements
- R1: While reset is active, `dout` is high impedance and `casc_n` is high at once, and after the next rising edge the device presents bit 0 again.
- R2: With `RST_HIGH`=1 a high `rst_oe` is reset; with `RST_HIGH`=0 a low `rst_oe` is reset; the other level lets the device run.
- R3: The k-th bit presented after reset is `CONTENT[k]`, least significant bit first. Bit 0 is on `dout` as soon as the device is selected and out of reset, before any clock edge.
- R4: The position advances by exactly one on each rising edge where the device is selected, out of reset and not finished.
- R5: While `sel_n` is high the position and the finished state hold, and on reselection the stream resumes with the same bit.
- R6: On the edge at which the last bit (index `DEPTH-1`) has been presented, the device becomes finished. In the same cycle it releases `dout` and pulls `casc_n` low.
- R7: A finished device stays finished, with its position saturated at `DEPTH-1`, until the next reset.
- R8: `dout` is high impedance whenever `sel_n` is high, reset is active, or the device is finished.
- R9: `casc_n` is high whenever `sel_n` is high or reset is active, even for a finished device.
- R10: In a chain of two devices with different contents and depths on one shared line, the line carries the first device's bits followed directly by the second device's bits. There is no idle cycle and no contention at the handoff, and the line floats once both are finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; a new bit follows each rising edge |
| sel_n | input | 1 | Active-low device select (driven by the previous device's `casc_n` in a chain) |
| rst_oe | input | 1 | Combined reset / output enable; active level set by `RST_HIGH` |
| dout | output | 1 | Tri-state serial data, high impedance when not driving |
| casc_n | output | 1 | Active-low cascade enable for the next device |

## Verification
The bench builds two chains. Each chain pairs a 24-bit device with a 40-bit device, and each device holds different, irregular contents. One chain uses `RST_HIGH`=1 and the other `RST_HIGH`=0, and both receive the same select and reset decisions, so the two reset polarities are compared against one model. The unequal, non-power-of-two depths put the handoff at a position where a counter wrap or an off-by-one terminal count shows up as a wrong or doubled bit. They also keep a full 64-bit sweep, saturation and a mid-stream pause cheap to reach many times under random select gaps and occasional resets.

// File: rtl/serial_cfg_mem.sv
module serial_cfg_mem #(
  parameter int DEPTH = 64,
  parameter int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter bit RST_HIGH = 1'b1,
  parameter logic [DEPTH-1:0] CONTENT = '0
) (
  input  logic clk,
  input  logic sel_n,
  input  logic rst_oe,
  output wire  dout,
  output logic casc_n
);

  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  logic [AW-1:0] cnt;
  logic          done;

  wire rst_act = RST_HIGH ? rst_oe : !rst_oe;
  wire live    = !rst_act && !sel_n;

  always_ff @(posedge clk) begin
    if (rst_act) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!sel_n && !done) begin
      if (cnt == TC) done <= 1'b1;
      else           cnt  <= cnt + 1'b1;
    end
  end

  assign dout   = (live && !done) ? CONTENT[cnt] : 1'bz;
  assign casc_n = !(live && done);

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst_act |=> (cnt == '0 && !done));

  p_single_step_r4: assert property (@(posedge clk) disable iff (rst_act)
    (!sel_n && !done && cnt != TC) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst_act)
    sel_n |=> ($stable(cnt) && $stable(done)));

  p_terminal_r6: assert property (@(posedge clk) disable iff (rst_act)
    (!sel_n && !done && cnt == TC) |=> done);

  p_sticky_sat_r7: assert property (@(posedge clk) disable iff (rst_act)
    done |=> (done && cnt == TC));

endmodule

// File: tb/serial_cfg_mem_test.sv
module serial_cfg_mem_test;
  localparam int D0 = 24;
  localparam int D1 = 40;
  localparam int DT = D0 + D1;
  localparam logic [D0-1:0] C0 = 24'hB4E1D2;
  localparam logic [D1-1:0] C1 = 40'h9C3A5E71F0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_h, sel_n;
  wire  rst_l = !rst_h;
  tri   bus_a, bus_b;
  wire  ca0, ca1, cb0, cb1;
  int   pos, total, bad;

  serial_cfg_mem #(.DEPTH(D0), .RST_HIGH(1'b1), .CONTENT(C0)) uut
    (.clk(clk), .sel_n(sel_n), .rst_oe(rst_h), .dout(bus_a), .casc_n(ca0));
  serial_cfg_mem #(.DEPTH(D1), .RST_HIGH(1'b1), .CONTENT(C1)) uut_a1
    (.clk(clk), .sel_n(ca0), .rst_oe(rst_h), .dout(bus_a), .casc_n(ca1));
  serial_cfg_mem #(.DEPTH(D0), .RST_HIGH(1'b0), .CONTENT(C0)) uut_b0
    (.clk(clk), .sel_n(sel_n), .rst_oe(rst_l), .dout(bus_b), .casc_n(cb0));
  serial_cfg_mem #(.DEPTH(D1), .RST_HIGH(1'b0), .CONTENT(C1)) uut_b1
    (.clk(clk), .sel_n(cb0), .rst_oe(rst_l), .dout(bus_b), .casc_n(cb1));

  function automatic logic exp_bit(int p);
    if (p < D0) return C0[p];
    if (p < DT) return C1[p-D0];
    return 1'bz;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pos=%0d act=%b exp=%b", tag, pos, act, exp);
    end
  endtask

  task automatic cycle(logic r, logic s, string tag);
    logic live, eb, e0, e1;
    string t;
    @(negedge clk);
    rst_h = r;
    sel_n = s;
    #2;
    live = !r && !s;
    eb   = live ? exp_bit(pos) : 1'bz;
    e0   = !(live && pos >= D0);
    e1   = !(live && pos >= DT);
    t = r ? "R1 R8 R9" : (s ? "R5 R8 R9" : (pos >= DT ? "R7 R8" : tag));
    check({t, " data"}, bus_a, eb);
    check({"R2 ", t, " data"}, bus_b, eb);
    check({"R6 R9 ", t, " casc0"}, ca0, e0);
    check({"R6 R9 ", t, " casc1"}, ca1, e1);
    check({"R2 R6 ", t, " casc0"}, cb0, e0);
    check({"R2 R6 ", t, " casc1"}, cb1, e1);
    @(posedge clk);
    if (r) pos = 0;
    else if (!s && pos < DT) pos++;
  endtask

  initial begin
    #500us;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    pos   = 0;
    rst_h = 1'b1;
    sel_n = 1'b1;
    void'($urandom(32'd11));
    repeat (3) cycle(1'b1, 1'b0, "R1");
    repeat (3) cycle(1'b1, 1'b1, "R1");
    repeat (DT + 6) cycle(1'b0, 1'b0, "R10 R3 R4");
    cycle(1'b1, 1'b0, "R1");
    repeat (10) cycle(1'b0, 1'b0, "R3 R4");
    repeat (4)  cycle(1'b0, 1'b1, "R5");
    repeat (20) cycle(1'b0, 1'b0, "R5 R6 R10");
    repeat (3)  cycle(1'b0, 1'b1, "R5");
    repeat (40) cycle(1'b0, 1'b0, "R7 R10");
    repeat (3)  cycle(1'b0, 1'b1, "R9");
    cycle(1'b1, 1'b0, "R1");
    for (int i = 0; i < 3000; i++) begin
      logic r, s;
      r = ($urandom % 100) < 1;
      s = ($urandom % 100) < 25;
      cycle(r, s, "R3 R4 R6 R10");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule